// File: doc/BRIEF.md
# Bidirectional Control Latch Bank

This block drives a small set of general-purpose latch pins that a line card uses to steer neighbouring devices, such as relays, test switches and the subscriber line interface. Each of the six pins is set as an input or an output by its own bit. An output pin drives the value held for it in a data register. An input pin is left undriven and reports the level that the outside world puts on it. A third, read-only register returns the level actually present on every pin.

The host reaches the three registers through a single select field, a write strobe, write data and a combinational read-data bus. Pin levels pass through a two-stage synchronizer before the block uses them. A fast-scan output carries the synchronized levels of pins 0 and 1 all the time. These two pins are meant for hook-state and ground-key detection. A valid pulse marks every change on them, so a controller can poll for line events with very little traffic.

After a channel reset, pins 0, 1, 4 and 5 float as inputs. Pins 2 and 3 come up as outputs driving low, so the line interface starts in a known state. Every direction bit can still be changed afterwards.

Top module: `ctl_latch_bank`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, pad_oe is 6'b001100 and pad_out is 6'b000000. The direction register reads 0x0C and the data register reads 0x00.
- R2: A write with select 0 loads the direction register. A 1 in bit i makes pin i an output. pad_oe shows the new value in the cycle after the write strobe, and a read with select 0 returns it.
- R3: A write with select 1 loads the data register, which a read with select 1 returns. pad_out[i] equals data bit i when pin i is an output and is 0 when pin i is an input. This takes effect in the cycle after the write strobe.
- R4: A read with select 2 returns the level of each pin, whatever its direction, two clock edges after that level was present at pad_in.
- R5: Bits 7 and 6 of every register read as zero, and writes to those bits have no effect.
- R6: A write with select 2 or select 3 changes no register and no pin. A read with select 3 returns zero.
- R7: scan_bits equals the levels of pins 1 and 0 (bit 1 = pin 1), three clock edges after they were present at pad_in.
- R8: scan_valid is high for one cycle whenever scan_bits has just changed, and low in every other cycle. A change on pins 2 to 5 causes no pulse.
- R9: Pins 2 and 3 can be made inputs after reset, and pins 0, 1, 4 and 5 can be made outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Channel reset, active low, asynchronous |
| host_wr | input | 1 | Write strobe for the selected register |
| host_sel | input | 2 | Register select: 0 direction, 1 data, 2 pin state, 3 spare |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register (combinational) |
| pad_in | input | 6 | Level present on each pin |
| pad_out | output | 6 | Value driven onto each pin |
| pad_oe | output | 6 | Drive enable per pin; low means high-impedance |
| scan_bits | output | 2 | Synchronized levels of pins 1 and 0 |
| scan_valid | output | 1 | One-cycle pulse when scan_bits changes |

## Verification
A register write is due on pad_oe, pad_out and the read bus at the first sample after the edge that took the strobe. A pin change is due on the readback two edges after it was driven, and on scan_bits, together with a one-cycle scan_valid, three edges after. The bench drives inputs on the falling edge and samples on a later falling edge. The directed tests sample one edge before each due point and again at it, so a result that comes early or late is caught. The bench closes the loop from pad_out back to pad_in for output pins, so the readback of a driven pin carries the same synchronizer delay.

// File: rtl/ctl_latch_pkg.sv
package ctl_latch_pkg;

    // Host register select codes; the readback register is read-only.
    typedef enum logic [1:0] {
        SEL_DIR   = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_PINS  = 2'd2,
        SEL_SPARE = 2'd3
    } host_sel_e;

endpackage

// File: rtl/ctl_latch_regs.sv
module ctl_latch_regs
    import ctl_latch_pkg::*;
#(
    parameter int                 NUM_PINS = 6,
    parameter int                 REG_W    = 8,
    parameter logic [NUM_PINS-1:0] DIR_RST  = 6'b001100,
    parameter logic [NUM_PINS-1:0] DATA_RST = 6'b000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          sel,
    input  logic [REG_W-1:0]    wdata,
    input  logic [NUM_PINS-1:0] pins_sync,
    output logic [NUM_PINS-1:0] dir,
    output logic [NUM_PINS-1:0] data,
    output logic [REG_W-1:0]    rdata
);

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] data;
    } regs_t;

    regs_t regs_d, regs_q;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[REG_W-1:NUM_PINS];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (sel)
                SEL_DIR:  regs_d.dir  = wdata[NUM_PINS-1:0];
                SEL_DATA: regs_d.data = wdata[NUM_PINS-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.dir  <= DIR_RST;
            regs_q.data <= DATA_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_DIR:  rdata[NUM_PINS-1:0] = regs_q.dir;
            SEL_DATA: rdata[NUM_PINS-1:0] = regs_q.data;
            SEL_PINS: rdata[NUM_PINS-1:0] = pins_sync;
            default:  rdata = '0;
        endcase
    end

    assign dir  = regs_q.dir;
    assign data = regs_q.data;

endmodule

// File: rtl/ctl_latch_sync.sv
module ctl_latch_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/ctl_latch_pad.sv
module ctl_latch_pad #(
    parameter int NUM_PINS = 6
) (
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] data,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    // One driver cell per pin: an input pin drives neither enable nor value.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
        assign pad_oe[i]  = dir[i];
        assign pad_out[i] = dir[i] & data[i];
    end

endmodule

// File: rtl/ctl_latch_scan.sv
module ctl_latch_scan #(
    parameter int SCAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SCAN_W-1:0] pins_sync,
    output logic [SCAN_W-1:0] scan_bits,
    output logic              scan_valid
);

    typedef struct packed {
        logic [SCAN_W-1:0] bits;
        logic              valid;
    } scan_t;

    scan_t scan_d, scan_q;

    always_comb begin
        scan_d.bits  = pins_sync;
        scan_d.valid = (pins_sync != scan_q.bits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign scan_bits  = scan_q.bits;
    assign scan_valid = scan_q.valid;

endmodule

// File: rtl/ctl_latch_bank.sv
module ctl_latch_bank #(
    parameter int                  NUM_PINS    = 6,
    parameter int                  REG_W       = 8,
    parameter int                  SEL_W       = 2,
    parameter int                  SYNC_STAGES = 2,
    parameter int                  SCAN_W      = 2,
    parameter logic [NUM_PINS-1:0] DIR_RST     = 6'b001100,
    parameter logic [NUM_PINS-1:0] DATA_RST    = 6'b000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [SEL_W-1:0]    host_sel,
    input  logic [REG_W-1:0]    host_wdata,
    output logic [REG_W-1:0]    host_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [SCAN_W-1:0]   scan_bits,
    output logic                scan_valid
);

    logic [NUM_PINS-1:0] pins_sync;
    logic [NUM_PINS-1:0] dir;
    logic [NUM_PINS-1:0] data;

    ctl_latch_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    ctl_latch_regs #(
        .NUM_PINS (NUM_PINS),
        .REG_W    (REG_W),
        .DIR_RST  (DIR_RST),
        .DATA_RST (DATA_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr),
        .sel       (host_sel),
        .wdata     (host_wdata),
        .pins_sync (pins_sync),
        .dir       (dir),
        .data      (data),
        .rdata     (host_rdata)
    );

    ctl_latch_pad #(
        .NUM_PINS (NUM_PINS)
    ) u_pad (
        .dir     (dir),
        .data    (data),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    ctl_latch_scan #(
        .SCAN_W (SCAN_W)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_sync  (pins_sync[SCAN_W-1:0]),
        .scan_bits  (scan_bits),
        .scan_valid (scan_valid)
    );

endmodule

// File: rtl/ctl_latch_bank_chk.sv
module ctl_latch_bank_chk #(
    parameter int                  NUM_PINS = 6,
    parameter int                  REG_W    = 8,
    parameter int                  SEL_W    = 2,
    parameter int                  SCAN_W   = 2,
    parameter logic [NUM_PINS-1:0] DIR_RST  = 6'b001100
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_wr,
    input logic [SEL_W-1:0]    host_sel,
    input logic [REG_W-1:0]    host_wdata,
    input logic [REG_W-1:0]    host_rdata,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [SCAN_W-1:0]   scan_bits,
    input logic                scan_valid
);

    // Edges seen since reset release, saturating at 3.
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> (pad_oe == DIR_RST && pad_out == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd0) |=> (pad_oe == $past(host_wdata[NUM_PINS-1:0])));

    // R3
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd1) |=> (pad_out == ($past(host_wdata[NUM_PINS-1:0]) & pad_oe)));

    // R3
    float_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    // R4
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && host_sel == 2'd2) |-> (host_rdata[NUM_PINS-1:0] == $past(pad_in, 2)));

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[REG_W-1:NUM_PINS] == '0));

    // R6
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel == 2'd3) |-> (host_rdata == '0));

    // R7
    scan_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (scan_bits == $past(pad_in[SCAN_W-1:0], 3)));

    // R8
    scan_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && scan_valid) |-> (scan_bits != $past(scan_bits)));

    // R8
    scan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !scan_valid) |-> $stable(scan_bits));

endmodule

bind ctl_latch_bank ctl_latch_bank_chk #(
    .NUM_PINS (NUM_PINS),
    .REG_W    (REG_W),
    .SEL_W    (SEL_W),
    .SCAN_W   (SCAN_W),
    .DIR_RST  (DIR_RST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .scan_bits  (scan_bits),
    .scan_valid (scan_valid)
);

// File: tb/ctl_latch_bank_bench.sv
module ctl_latch_bank_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [5:0] pad_in;
    logic [5:0] pad_out;
    logic [5:0] pad_oe;
    logic [1:0] scan_bits;
    logic       scan_valid;
    logic [5:0] ext = 6'b000000;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Outside world: driven pins loop back, floating pins take the external level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    ctl_latch_bank u_ctl_latch_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .scan_bits  (scan_bits),
        .scan_valid (scan_valid)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] wsel;
        logic [7:0] wdata;
        logic [5:0] ext;
        logic [1:0] rsel;
        logic [7:0] exp_rd;
        logic [5:0] exp_oe;
        logic [5:0] exp_out;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd0, 8'h00, 6'h00, 2'd0, 8'h0C, 6'h0C, 6'h00}, // R1 reset read
        '{1'b1, 2'd1, 8'hFF, 6'h00, 2'd1, 8'h3F, 6'h0C, 6'h0C}, // R3 R5
        '{1'b1, 2'd0, 8'hF0, 6'h00, 2'd0, 8'h30, 6'h30, 6'h30}, // R2 R5 R9
        '{1'b0, 2'd0, 8'h00, 6'h03, 2'd2, 8'h33, 6'h30, 6'h30}, // R4
        '{1'b1, 2'd2, 8'hFF, 6'h03, 2'd2, 8'h33, 6'h30, 6'h30}, // R6
        '{1'b1, 2'd0, 8'h00, 6'h2A, 2'd2, 8'h2A, 6'h00, 6'h00}, // R9 R4
        '{1'b1, 2'd1, 8'h05, 6'h2A, 2'd1, 8'h05, 6'h00, 6'h00}, // R3
        '{1'b1, 2'd0, 8'h3F, 6'h2A, 2'd2, 8'h05, 6'h3F, 6'h05}, // R4 R9
        '{1'b1, 2'd3, 8'h77, 6'h2A, 2'd3, 8'h00, 6'h3F, 6'h05}  // R6
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] val);
        host_wr = 1'b1;
        host_sel = sel;
        host_wdata = val;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: state while reset is held
        cyc(3);
        check("R1", "pad_oe in reset", 32'(pad_oe), 32'h0C);
        check("R1", "pad_out in reset", 32'(pad_out), 32'h00);
        rst_n = 1'b1;
        cyc(1);
        check("R1", "pad_oe after release", 32'(pad_oe), 32'h0C);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            ext = VECS[v].ext;
            if (VECS[v].wr) wr_reg(VECS[v].wsel, VECS[v].wdata);
            cyc(3);
            host_sel = VECS[v].rsel;
            #1;
            check("R2/R3/R4/R5/R6/R9 table rdata", $sformatf("vec%0d", v), 32'(host_rdata), 32'(VECS[v].exp_rd));
            check("R2/R3/R9 table pad_oe", $sformatf("vec%0d", v), 32'(pad_oe), 32'(VECS[v].exp_oe));
            check("R3 table pad_out", $sformatf("vec%0d", v), 32'(pad_out), 32'(VECS[v].exp_out));
            cyc(1);
        end

        // R2: direction takes effect right after the write edge
        wr_reg(2'd0, 8'h00);
        check("R2", "pad_oe after write edge", 32'(pad_oe), 32'h00);
        wr_reg(2'd1, 8'h3F);
        check("R3", "pad_out while inputs", 32'(pad_out), 32'h00);
        wr_reg(2'd0, 8'h0C);
        check("R3", "pad_out after dir write", 32'(pad_out), 32'h0C);
        wr_reg(2'd0, 8'h00);

        // R4: readback latency of exactly two edges
        ext = 6'h00;
        cyc(4);
        host_sel = 2'd2;
        ext = 6'h10;
        cyc(1);
        check("R4", "readback one edge", 32'(host_rdata), 32'h00);
        cyc(1);
        check("R4", "readback two edges", 32'(host_rdata), 32'h10);

        // R7 R8: scan on pin 0 change
        cyc(4);
        check("R8", "scan_valid idle", 32'(scan_valid), 32'h0);
        ext = 6'h11;
        cyc(2);
        check("R7", "scan_bits early", 32'(scan_bits), 32'h0);
        check("R8", "scan_valid early", 32'(scan_valid), 32'h0);
        cyc(1);
        check("R7", "scan_bits due", 32'(scan_bits), 32'h1);
        check("R8", "scan_valid due", 32'(scan_valid), 32'h1);
        cyc(1);
        check("R8", "scan_valid one cycle", 32'(scan_valid), 32'h0);
        check("R7", "scan_bits held", 32'(scan_bits), 32'h1);

        // R8: change on pins 2..5 only, no pulse
        ext = 6'h2D;
        for (int k = 0; k < 5; k++) begin
            cyc(1);
            check("R8", "no pulse upper pins", 32'(scan_valid), 32'h0);
        end

        // R7 R8: both scan pins change together
        ext = 6'h2E;
        cyc(3);
        check("R7", "scan_bits both", 32'(scan_bits), 32'h2);
        check("R8", "scan_valid both", 32'(scan_valid), 32'h1);
        cyc(1);
        check("R8", "scan_valid drops", 32'(scan_valid), 32'h0);

        // R7 R9: scan pins made outputs report the driven value
        wr_reg(2'd1, 8'h03);
        wr_reg(2'd0, 8'h03);
        cyc(3);
        check("R7", "scan of driven pins", 32'(scan_bits), 32'h3);

        // R1: reset again restores defaults from a changed state
        rst_n = 1'b0;
        cyc(1);
        host_sel = 2'd0;
        #1;
        check("R1", "dir after reset", 32'(host_rdata), 32'h0C);
        host_sel = 2'd1;
        #1;
        check("R1", "data after reset", 32'(host_rdata), 32'h00);
        check("R1", "pad_out after reset", 32'(pad_out), 32'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule